// File: doc/BRIEF.md
# Performance-Monitor Reset Signal Generator

This block produces the control signal that tells performance-monitoring counters to copy their running totals into holding registers and then clear. A two-bit mode field selects the source of that signal. It can come from an external pin, from an internal timer whose high and low phases are programmed separately, or from a fixed-shape pulse that software launches.

A single write strobe acts on the block's reset bit. In timer mode the strobe restarts the timer. In software mode it launches one pulse that is high for 100 cycles and then low for 100 cycles. Strobes that arrive while a pulse window is open are ignored. The block also drives a bidirectional pin. In the timer and software modes it drives the generated signal onto that pin with the output enable asserted. In the external modes it releases the pin.

Top module: `pm_ctrl_gen`

## Requirements
- R1: After reset, with mode 00 applied, `pm_ctrl_o`, `pin_o` and `pin_oe_o` are all 0.
- R2: In modes 00 and 10, a change on `ext_pm_i` reaches `pm_ctrl_o` at the third rising clock edge after it is applied, through a two-flop synchroniser. In these modes `pin_oe_o` is 0 and `pin_o` is 0.
- R3: In modes 01 and 11, `pin_oe_o` is 1 and `pin_o` equals `pm_ctrl_o`.
- R4: In mode 01, when `rst_bit_we_i` is sampled high at edge E0, `pm_ctrl_o` is still 0 after E0 and is 1 after edge E0+1, where the high phase starts with a fresh count.
- R5: In mode 01, after a restart the timer alternates without end. The high phase lasts `high_cnt_i` cycles and the low phase lasts `low_cnt_i` cycles; both counts are 24 bits wide.
- R6: A programmed phase count of 0 gives a phase of 1 cycle.
- R7: On entry to mode 01, `pm_ctrl_o` stays 0 until the first restart strobe.
- R8: In mode 11, a strobe sampled at edge E0 makes `pm_ctrl_o` 1 from edge E0+1 for 100 cycles. It is then 0 for 100 cycles, and the pulse window covers those 200 cycles.
- R9: A strobe that arrives during the 200-cycle pulse window has no effect on `pm_ctrl_o`. A strobe after the window launches a new pulse.
- R10: When `mode_i` changes, `pm_ctrl_o` is 0 after the next edge. The timer and the pulse sequencer return to idle, so no pulse or phase carries over into the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Source select: 00/10 external, 01 timer, 11 software pulse |
| rst_bit_we_i | input | 1 | One-cycle strobe for a write of 1 to the reset bit |
| high_cnt_i | input | 24 | Timer high-phase length in clock cycles |
| low_cnt_i | input | 24 | Timer low-phase length in clock cycles |
| ext_pm_i | input | 1 | External control input, asynchronous |
| pm_ctrl_o | output | 1 | Control signal to the performance counters |
| pin_o | output | 1 | Value driven onto the bidirectional pin |
| pin_oe_o | output | 1 | Output enable of the bidirectional pin |

## Verification
The hardest case to reach is a strobe that lands inside a running software pulse, in particular during its low half. In that half the output is already quiet, so a strobe that was wrongly accepted would show only as a shifted or extra pulse. The bench strobes once in the high half and once deep in the low half. It then checks that the high run is still exactly 100 cycles and the low run exactly 100 cycles, and that a strobe after the window starts a fresh pulse. Programmed phase lengths are measured as run lengths over two phases for each vector, and these vectors include zero counts.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_EXT_A = 2'b00,
    MODE_TIMER = 2'b01,
    MODE_EXT_B = 2'b10,
    MODE_SOFT  = 2'b11
  } pm_mode_e;

  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,
    TMR_HIGH = 2'd1,
    TMR_LOW  = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/pm_sync2.sv
module pm_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pm_phase_timer.sv
module pm_phase_timer
  import pm_ctrl_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  output logic             level_o
);
  tmr_state_e       state_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] high_eff, low_eff;

  // zero count behaves as a one-cycle phase
  assign high_eff = (high_cnt_i == '0) ? CNT_W'(1) : high_cnt_i;
  assign low_eff  = (low_cnt_i  == '0) ? CNT_W'(1) : low_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      rem_q   <= '0;
    end else if (clear_i || !en_i) begin
      state_q <= TMR_IDLE;
      rem_q   <= '0;
    end else if (restart_i) begin
      state_q <= TMR_HIGH;
      rem_q   <= high_eff - CNT_W'(1);
    end else begin
      unique case (state_q)
        TMR_HIGH: begin
          if (rem_q == '0) begin
            state_q <= TMR_LOW;
            rem_q   <= low_eff - CNT_W'(1);
          end else begin
            rem_q <= rem_q - CNT_W'(1);
          end
        end
        TMR_LOW: begin
          if (rem_q == '0) begin
            state_q <= TMR_HIGH;
            rem_q   <= high_eff - CNT_W'(1);
          end else begin
            rem_q <= rem_q - CNT_W'(1);
          end
        end
        default: begin
          state_q <= TMR_IDLE;
          rem_q   <= '0;
        end
      endcase
    end
  end

  assign level_o = (state_q == TMR_HIGH);

  a_r4_restart_enters_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && restart_i) |=> (state_q == TMR_HIGH));

  a_r5_high_expires_to_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i && !restart_i && state_q == TMR_HIGH && rem_q == '0)
      |=> (state_q == TMR_LOW));

  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_IDLE && !restart_i) |=> (state_q == TMR_IDLE));
endmodule

// File: rtl/pm_sw_pulse.sv
module pm_sw_pulse #(
  parameter int HI_CYC = 100,
  parameter int LO_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  output logic pulse_o
);
  localparam int TOTAL = HI_CYC + LO_CYC;
  localparam int CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] LAST   = CW'(TOTAL - 1);
  localparam logic [CW-1:0] HI_END = CW'(HI_CYC);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign pulse_o = busy_q && (cnt_q < HI_END);

  a_r9_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !clear_i && cnt_q != LAST)
      |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));

  a_r8_window_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == LAST) |=> !pulse_o);
endmodule

// File: rtl/pm_ctrl_gen.sv
module pm_ctrl_gen
  import pm_ctrl_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int SYNC_LEN = 2,
  parameter int PULSE_HI = 100,
  parameter int PULSE_LO = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             rst_bit_we_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic             ext_pm_i,
  output logic             pm_ctrl_o,
  output logic             pin_o,
  output logic             pin_oe_o
);
  pm_mode_e mode_cur, mode_q;
  logic     mode_chg;
  logic     ext_sync, tmr_level, sw_level;
  logic     tmr_en, tmr_restart, sw_start;
  logic     pm_ctrl_q, pm_ctrl_d;

  assign mode_cur    = pm_mode_e'(mode_i);
  assign mode_chg    = (mode_cur != mode_q);
  assign tmr_en      = (mode_cur == MODE_TIMER);
  assign tmr_restart = tmr_en && rst_bit_we_i;
  assign sw_start    = (mode_cur == MODE_SOFT) && rst_bit_we_i;

  pm_sync2 #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_pm_i),
    .q_o   (ext_sync)
  );

  pm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (mode_chg),
    .en_i      (tmr_en),
    .restart_i (tmr_restart),
    .high_cnt_i(high_cnt_i),
    .low_cnt_i (low_cnt_i),
    .level_o   (tmr_level)
  );

  pm_sw_pulse #(.HI_CYC(PULSE_HI), .LO_CYC(PULSE_LO)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(mode_chg),
    .start_i(sw_start),
    .pulse_o(sw_level)
  );

  always_comb begin
    unique case (mode_cur)
      MODE_TIMER: pm_ctrl_d = tmr_level;
      MODE_SOFT:  pm_ctrl_d = sw_level;
      default:    pm_ctrl_d = ext_sync;
    endcase
    if (mode_chg) pm_ctrl_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_EXT_A;
      pm_ctrl_q <= 1'b0;
    end else begin
      mode_q    <= mode_cur;
      pm_ctrl_q <= pm_ctrl_d;
    end
  end

  assign pm_ctrl_o = pm_ctrl_q;
  assign pin_oe_o  = mode_i[0];
  assign pin_o     = mode_i[0] ? pm_ctrl_q : 1'b0;

  a_r10_mode_change_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !pm_ctrl_o);

  a_r2_ext_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[0] && !mode_chg) |=> (pm_ctrl_o == $past(ext_sync)));

  a_r3_timer_drives_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_cur == MODE_TIMER && !mode_chg) |=> (pm_ctrl_o == $past(tmr_level)));

  a_r2_pin_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o);
endmodule

// File: tb/pm_ctrl_gen_test.sv
module pm_ctrl_gen_test;
  localparam int CNT_W = 24;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic             rst_bit_we_i = 1'b0;
  logic [CNT_W-1:0] high_cnt_i = '0;
  logic [CNT_W-1:0] low_cnt_i = '0;
  logic             ext_pm_i = 1'b0;
  logic             pm_ctrl_o, pin_o, pin_oe_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  pm_ctrl_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .rst_bit_we_i(rst_bit_we_i),
    .high_cnt_i(high_cnt_i), .low_cnt_i(low_cnt_i), .ext_pm_i(ext_pm_i),
    .pm_ctrl_o(pm_ctrl_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  // {high count, low count}
  localparam logic [2*CNT_W-1:0] VEC [5] = '{
    {24'd3, 24'd5}, {24'd1, 24'd1}, {24'd0, 24'd2}, {24'd6, 24'd0}, {24'd12, 24'd4}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    rst_bit_we_i = 1'b1;
    tick();
    rst_bit_we_i = 1'b0;
  endtask

  task automatic run_len(input logic lvl, input int limit, output int n);
    n = 0;
    while (pm_ctrl_o == lvl && n < limit) begin
      n++;
      tick();
    end
  endtask

  task automatic go_mode(input logic [1:0] m);
    mode_i = m;
    tick(2);
  endtask

  initial begin
    int n, eh, el;
    tick(2);
    // R1 reset state
    check(pm_ctrl_o == 0 && pin_o == 0 && pin_oe_o == 0, "R1",
          {pm_ctrl_o, pin_o, pin_oe_o}, 0);
    rst_ni = 1'b1;
    tick();

    // timer vectors: R4 R5 R6 R7 R3
    for (int v = 0; v < 5; v++) begin
      go_mode(2'b00);
      high_cnt_i = VEC[v][2*CNT_W-1:CNT_W];
      low_cnt_i  = VEC[v][CNT_W-1:0];
      eh = (high_cnt_i == 0) ? 1 : int'(high_cnt_i);
      el = (low_cnt_i == 0) ? 1 : int'(low_cnt_i);
      go_mode(2'b01);
      tick(3);
      check(pm_ctrl_o == 0, "R7 idle before restart", pm_ctrl_o, 0);
      check(pin_oe_o == 1 && pin_o == pm_ctrl_o, "R3 timer pin", pin_oe_o, 1);
      strobe();
      check(pm_ctrl_o == 0, "R4 still low after strobe edge", pm_ctrl_o, 0);
      tick();
      check(pm_ctrl_o == 1, "R4 high on second edge", pm_ctrl_o, 1);
      check(pin_o == 1, "R3 pin follows", pin_o, 1);
      run_len(1'b1, 100, n);
      check(n == eh, "R5/R6 high phase", n, eh);
      run_len(1'b0, 100, n);
      check(n == el, "R5/R6 low phase", n, el);
      run_len(1'b1, 100, n);
      check(n == eh, "R5 second high phase", n, eh);
    end

    // restart mid low phase resynchronises: R4
    high_cnt_i = 24'd4; low_cnt_i = 24'd20;
    strobe(); tick();
    run_len(1'b1, 100, n);
    tick(5);
    strobe();
    check(pm_ctrl_o == 0, "R4 restart in low phase, edge 1", pm_ctrl_o, 0);
    tick();
    check(pm_ctrl_o == 1, "R4 restart in low phase, edge 2", pm_ctrl_o, 1);

    // mode change while high: R10
    go_mode(2'b00);
    mode_i = 2'b11;
    tick();
    check(pm_ctrl_o == 0, "R10 low after mode change", pm_ctrl_o, 0);
    tick(10);
    check(pm_ctrl_o == 0, "R10 no carried pulse", pm_ctrl_o, 0);
    check(pin_oe_o == 1, "R3 soft mode enable", pin_oe_o, 1);

    // software pulse: R8 R9
    strobe();
    check(pm_ctrl_o == 0, "R8 low after strobe edge", pm_ctrl_o, 0);
    tick();
    check(pm_ctrl_o == 1, "R8 high on second edge", pm_ctrl_o, 1);
    tick(9);
    strobe(); // inside high half
    run_len(1'b1, 300, n);
    check(n == 90, "R9 high half unchanged", n, 90);
    tick(39);
    strobe(); // inside low half
    n = 0;
    for (int i = 0; i < 70; i++) begin
      if (pm_ctrl_o != 0) n++;
      tick();
    end
    check(n == 0, "R9 low half stays low", n, 0);
    strobe();
    tick();
    check(pm_ctrl_o == 1, "R9 new pulse after window", pm_ctrl_o, 1);
    run_len(1'b1, 300, n);
    check(n == 100, "R8 high length", n, 100);
    run_len(1'b0, 100, n);
    check(n == 100, "R8 low length", n, 100);

    // mode change mid pulse: R10
    strobe(); tick(5);
    mode_i = 2'b01;
    tick();
    check(pm_ctrl_o == 0, "R10 pulse cut by mode change", pm_ctrl_o, 0);
    tick(20);
    check(pm_ctrl_o == 0, "R10 timer idle after change", pm_ctrl_o, 0);

    // external path: R2
    go_mode(2'b00);
    ext_pm_i = 1'b1;
    tick(2);
    check(pm_ctrl_o == 0, "R2 not yet through synchroniser", pm_ctrl_o, 0);
    tick();
    check(pm_ctrl_o == 1, "R2 external on third edge", pm_ctrl_o, 1);
    check(pin_oe_o == 0 && pin_o == 0, "R2 pin released", {pin_oe_o, pin_o}, 0);
    strobe(); tick(3);
    check(pm_ctrl_o == 1, "R2 strobe no effect in external mode", pm_ctrl_o, 1);
    mode_i = 2'b10;
    tick();
    check(pm_ctrl_o == 0, "R10 low on change to mode 10", pm_ctrl_o, 0);
    tick();
    check(pm_ctrl_o == 1, "R2 mode 10 passes external", pm_ctrl_o, 1);
    ext_pm_i = 1'b0;
    tick(3);
    check(pm_ctrl_o == 0, "R2 mode 10 falling", pm_ctrl_o, 0);
    check(pin_oe_o == 0, "R2 mode 10 enable", pin_oe_o, 0);

    summary();
    $finish;
  end
endmodule